// File: doc/BRIEF.md
# I2C Channel Select Controller

This block is an I2C target that owns a one-byte control register for a two-way downstream bus switch. A bus master addresses it, writes a control byte that names the channel to connect, and may read the register back. The readback also carries two interrupt flags, one for each downstream channel. Clock stretching, 10-bit addressing and general call are not handled. The pass switches and pull-ups themselves sit outside the block. It only produces a channel-enable level and a one-hot select vector.

SCL and SDA are oversampled by the system clock through two-flop synchronizers. START and STOP are recognised as SDA edges while SCL is high. The system clock must run at least eight times faster than SCL. A written selection is held in the control register and reaches the channel outputs only when a STOP is seen. The switch is therefore never reconfigured in the middle of a transfer. The block drives SDA only as an open-drain pull-low request. No data stream crosses the block's edge, so all pins are plain levels with no valid/ready handshake.

Top module: `i2c_chsel_ctrl`

## Requirements
- R1: The block acknowledges (pulls SDA low during the ninth clock) only the 7-bit address whose upper four bits are 1110 and whose lower three bits equal `addr_strap_i` (bit 2 to bit 0). Any other address is left unacknowledged, and the rest of that transfer is ignored.
- R2: The eighth bit after START selects the direction. A 0 makes it a write, and a 1 makes it a read that returns the register without changing it.
- R3: On a write, every data byte is acknowledged and stored. When several bytes arrive in one transfer, the last one is the one kept.
- R4: Register bit 2 enables routing. While it is set, bit 0 picks the channel: 0 raises `chan_sel_o[0]` and 1 raises `chan_sel_o[1]`. Bit 1 is stored but does not affect routing. While bit 2 is clear, `chan_en_o` is 0 and `chan_sel_o` is 00.
- R5: The channel outputs keep their old value while a write is in progress and across a repeated START. They take the register value only after a STOP.
- R6: The read value has bits 7:6 equal to 0. Bit 5 is 1 while `irq_n_i[1]` is low, and bit 4 is 1 while `irq_n_i[0]` is low. Bits 3:0 are the stored low nibble of the last written byte. Written bits 7:4 have no effect.
- R7: During a read, a master ACK makes the block send the register again. A master NACK makes it release SDA and ignore the bus until the next START.
- R8: Reset clears the register and the active selection, so no channel is enabled, and releases SDA.
- R9: The block changes `sda_pull_o` only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| sda_pull_o | output | 1 | 1 requests the open-drain driver to pull SDA low |
| addr_strap_i | input | 3 | Low three bits of the target address |
| irq_n_i | input | 2 | Active-low interrupt lines from channel 1 (bit 1) and channel 0 (bit 0) |
| chan_en_o | output | 1 | A downstream channel is connected |
| chan_sel_o | output | 2 | One-hot channel select, bit n for channel n |

## Verification
The assertions assume a well-formed master. Each SCL high and low phase lasts several system clocks. SDA moves only while SCL is low, except for START and STOP. The master never issues START or STOP while the block is pulling SDA low. Under these conditions, SDA changes by the block fall inside SCL low phases, and output changes always follow a detected STOP. The bench master holds each quarter of the SCL period for eight system clocks and changes SDA only in the middle of the low phase. It issues repeated START and STOP only after a released acknowledge slot or a NACK.

// File: rtl/chsel_pkg.sv
package chsel_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam logic [3:0]  ADDR_HI   = 4'b1110;
  localparam int unsigned CTRL_W    = 4;
  localparam int unsigned EN_BIT    = 2;
  localparam int unsigned FLAG_LSB  = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_DATA,
    ST_WR_ACK,
    ST_RD_DATA,
    ST_RD_ACK
  } tgt_state_e;
endpackage

// File: rtl/chsel_sync.sv
module chsel_sync #(
  parameter int unsigned      WIDTH   = 1,
  parameter int unsigned      STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/chsel_bus_events.sv
module chsel_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
endmodule

// File: rtl/chsel_target_fsm.sv
module chsel_target_fsm
  import chsel_pkg::*;
#(
  parameter int unsigned STRAP_W = 3,
  parameter int unsigned DATA_W  = BYTE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               sda_s,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               scl_rise_i,
  input  logic               scl_fall_i,
  input  logic [DATA_W-1:0]  rd_byte_i,
  output logic               wr_stb_o,
  output logic [DATA_W-1:0]  wr_byte_o,
  output logic               sda_pull_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

  tgt_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] rx_q, tx_q;
  logic              rw_q, mack_q, pull_q, stb_q;
  logic              addr_hit;

  assign addr_hit = (rx_q[DATA_W-1:1] == {ADDR_HI, strap_i});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      pull_q  <= 1'b0;
      stb_q   <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      if (stop_i) begin
        state_q <= ST_IDLE;
        pull_q  <= 1'b0;
      end else if (start_i) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        pull_q  <= 1'b0;
      end else begin
        case (state_q)
          ST_ADDR, ST_WR_DATA: begin
            if (scl_rise_i && cnt_q != FULL) begin
              rx_q  <= {rx_q[DATA_W-2:0], sda_s};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == FULL) begin
              if (state_q == ST_ADDR) begin
                if (addr_hit) begin
                  pull_q  <= 1'b1;
                  rw_q    <= rx_q[0];
                  state_q <= ST_ADDR_ACK;
                end else begin
                  state_q <= ST_IDLE;
                end
              end else begin
                stb_q   <= 1'b1;
                pull_q  <= 1'b1;
                state_q <= ST_WR_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall_i) begin
              cnt_q <= '0;
              if (rw_q) begin
                tx_q    <= rd_byte_i;
                pull_q  <= ~rd_byte_i[DATA_W-1];
                state_q <= ST_RD_DATA;
              end else begin
                pull_q  <= 1'b0;
                state_q <= ST_WR_DATA;
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall_i) begin
              pull_q  <= 1'b0;
              cnt_q   <= '0;
              state_q <= ST_WR_DATA;
            end
          end
          ST_RD_DATA: begin
            if (scl_rise_i) begin
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i) begin
              if (cnt_q == FULL) begin
                pull_q  <= 1'b0;
                state_q <= ST_RD_ACK;
              end else begin
                tx_q   <= {tx_q[DATA_W-2:0], 1'b0};
                pull_q <= ~tx_q[DATA_W-2];
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise_i) begin
              mack_q <= ~sda_s;
            end else if (scl_fall_i) begin
              if (mack_q) begin
                cnt_q   <= '0;
                tx_q    <= rd_byte_i;
                pull_q  <= ~rd_byte_i[DATA_W-1];
                state_q <= ST_RD_DATA;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign wr_stb_o   = stb_q;
  assign wr_byte_o  = rx_q;
  assign sda_pull_o = pull_q;
endmodule

// File: rtl/chsel_route.sv
module chsel_route
  import chsel_pkg::*;
#(
  parameter int unsigned CH_N   = 2,
  parameter int unsigned DATA_W = BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb_i,
  input  logic [DATA_W-1:0] wr_byte_i,
  input  logic              stop_i,
  input  logic [CH_N-1:0]   irq_i,
  output logic [DATA_W-1:0] rd_byte_o,
  output logic              chan_en_o,
  output logic [CH_N-1:0]   chan_sel_o
);
  localparam int unsigned SEL_W = (CH_N > 1) ? $clog2(CH_N) : 1;

  logic [CTRL_W-1:0] ctrl_q, act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      act_q  <= '0;
    end else begin
      if (wr_stb_i) ctrl_q <= wr_byte_i[CTRL_W-1:0];
      if (stop_i)   act_q  <= ctrl_q;
    end
  end

  always_comb begin
    rd_byte_o                     = '0;
    rd_byte_o[CTRL_W-1:0]         = ctrl_q;
    rd_byte_o[FLAG_LSB +: CH_N]   = irq_i;
  end

  assign chan_en_o = act_q[EN_BIT];

  for (genvar c = 0; c < CH_N; c++) begin : g_sel
    assign chan_sel_o[c] = chan_en_o && (act_q[SEL_W-1:0] == SEL_W'(c));
  end
endmodule

// File: rtl/i2c_chsel_ctrl.sv
module i2c_chsel_ctrl
  import chsel_pkg::*;
#(
  parameter int unsigned STRAP_W     = 3,
  parameter int unsigned CH_N        = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_pull_o,
  input  logic [STRAP_W-1:0] addr_strap_i,
  input  logic [CH_N-1:0]    irq_n_i,
  output logic               chan_en_o,
  output logic [CH_N-1:0]    chan_sel_o
);
  logic              scl_s, sda_s;
  logic [CH_N-1:0]   irq_n_s;
  logic              start_det, stop_det, scl_rise, scl_fall;
  logic              wr_stb;
  logic [BYTE_W-1:0] wr_byte, rd_byte;

  chsel_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d_i({scl_i, sda_i}), .q_o({scl_s, sda_s})
  );

  chsel_sync #(.WIDTH(CH_N), .STAGES(SYNC_STAGES), .RST_VAL({CH_N{1'b1}})) u_irq_sync (
    .clk(clk), .rst_n(rst_n), .d_i(irq_n_i), .q_o(irq_n_s)
  );

  chsel_bus_events u_events (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .start_o(start_det), .stop_o(stop_det),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall)
  );

  chsel_target_fsm #(.STRAP_W(STRAP_W), .DATA_W(BYTE_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .strap_i(addr_strap_i), .sda_s(sda_s),
    .start_i(start_det), .stop_i(stop_det),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .rd_byte_i(rd_byte), .wr_stb_o(wr_stb), .wr_byte_o(wr_byte),
    .sda_pull_o(sda_pull_o)
  );

  chsel_route #(.CH_N(CH_N), .DATA_W(BYTE_W)) u_route (
    .clk(clk), .rst_n(rst_n), .wr_stb_i(wr_stb), .wr_byte_i(wr_byte),
    .stop_i(stop_det), .irq_i(~irq_n_s), .rd_byte_o(rd_byte),
    .chan_en_o(chan_en_o), .chan_sel_o(chan_sel_o)
  );
endmodule

// File: rtl/i2c_chsel_ctrl_chk.sv
module i2c_chsel_ctrl_chk #(
  parameter int unsigned CH_N = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            stop_det,
  input logic            scl_s,
  input logic            sda_pull_o,
  input logic            chan_en_o,
  input logic [CH_N-1:0] chan_sel_o
);
  // R5: routing outputs move only in the cycle after a detected STOP
  a_r5_apply_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({chan_en_o, chan_sel_o}) |-> $past(stop_det));

  // R4: an enabled switch selects exactly one channel
  a_r4_onehot_when_on: assert property (@(posedge clk) disable iff (!rst_n)
    chan_en_o |-> $onehot(chan_sel_o));

  // R4: a disabled switch selects nothing
  a_r4_none_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en_o |-> (chan_sel_o == '0));

  // R9: the data line request moves only while the clock line is low
  a_r9_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> !scl_s);

  // R7: a STOP always leaves SDA released
  a_r7_release_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull_o);
endmodule

bind i2c_chsel_ctrl i2c_chsel_ctrl_chk #(.CH_N(CH_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .stop_det(stop_det), .scl_s(scl_s),
  .sda_pull_o(sda_pull_o), .chan_en_o(chan_en_o), .chan_sel_o(chan_sel_o)
);

// File: tb/test_i2c_chsel_ctrl.sv
module test_i2c_chsel_ctrl;
  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic [1:0] irq_n = 2'b11;
  logic       sda_pull, chan_en;
  logic [1:0] chan_sel;
  wire        sda_bus = sda_m & ~sda_pull;

  int compared = 0, mismatched = 0, r9_viol = 0;
  bit done = 1'b0;
  logic [3:0] exp_ctrl = '0, exp_act = '0;
  logic [7:0] wbuf [4];

  always #2 clk = ~clk;

  i2c_chsel_ctrl i_i2c_chsel_ctrl (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .addr_strap_i(strap), .irq_n_i(irq_n),
    .chan_en_o(chan_en), .chan_sel_o(chan_sel)
  );

  function automatic logic [2:0] route_of(input logic [3:0] a);
    return {a[2], a[2] & a[0], a[2] & ~a[0]};
  endfunction

  function automatic logic [7:0] rb_of(input logic [3:0] c, input logic [1:0] irqn);
    return {2'b00, ~irqn[1], ~irqn[0], c};
  endfunction

  function automatic logic [6:0] my_addr();
    return {4'b1110, strap};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R9 monitor: a change of the pull request while SCL is high is a violation
  logic pull_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && sda_pull !== pull_prev && scl_m) r9_viol++;
    pull_prev <= sda_pull;
  end

  task automatic qwait(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait();
    sda_m = 1'b0; qwait(); scl_m = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait(); scl_m = 1'b1; qwait(); sda_m = 1'b1; qwait();
    exp_act = exp_ctrl;
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; qwait(); scl_m = 1'b1; qwait(); qwait(); scl_m = 1'b0; qwait();
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait(); b = sda_bus; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin recv_bit(b); d[i] = b; end
    send_bit(~ack);
  endtask

  // START, address with write, n data bytes from wbuf; no STOP
  task automatic wr_xfer(input logic [6:0] addr, input int n);
    logic ack;
    bus_start();
    send_byte({addr, 1'b0}, ack);
    check("R1 address ack on write", ack, addr == my_addr());
    if (ack) begin
      for (int i = 0; i < n; i++) begin
        send_byte(wbuf[i], ack);
        check("R3 data byte ack", ack, 1'b1);
        exp_ctrl = wbuf[i][3:0];
      end
    end
  endtask

  // START, address with read, n bytes (ACK all but last); no STOP
  task automatic rd_xfer(input logic [6:0] addr, input int n);
    logic ack;
    logic [7:0] d;
    bus_start();
    send_byte({addr, 1'b1}, ack);
    check("R1 address ack on read", ack, addr == my_addr());
    if (ack) begin
      for (int i = 0; i < n; i++) begin
        recv_byte(d, i < n - 1);
        check("R2 R6 readback value", d, rb_of(exp_ctrl, irq_n));
      end
      check("R7 SDA released after NACK", sda_pull, 1'b0);
    end
  endtask

  task automatic check_route(input string req);
    check(req, {chan_en, chan_sel}, route_of(exp_act));
  endtask

  initial begin
    void'($urandom(32'd24681357));
    repeat (5) @(negedge clk);
    check("R8 reset outputs", {chan_en, chan_sel, sda_pull}, 4'b0000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 after reset release", {chan_en, chan_sel, sda_pull}, 4'b0000);

    // R4/R5: enable channel 1, held until STOP
    wbuf[0] = 8'h05;
    wr_xfer(my_addr(), 1);
    check_route("R5 held before STOP");
    check("R5 not yet applied", chan_en, 1'b0);
    bus_stop();
    check("R4 R5 channel 1 after STOP", {chan_en, chan_sel}, 3'b110);

    // R1: wrong address leaves everything untouched
    wbuf[0] = 8'h04;
    wr_xfer(my_addr() ^ 7'h10, 1);
    bus_stop();
    check("R1 wrong address no effect", {chan_en, chan_sel}, 3'b110);
    rd_xfer(my_addr(), 1);
    bus_stop();

    // R3/R4: several bytes, last one kept; bit 1 does not route
    wbuf[0] = 8'h04; wbuf[1] = 8'h07; wbuf[2] = 8'h06;
    wr_xfer(my_addr(), 3);
    bus_stop();
    check("R3 R4 last byte routes channel 0", {chan_en, chan_sel}, 3'b101);
    rd_xfer(my_addr(), 1);
    bus_stop();

    // R5: repeated START does not apply
    wbuf[0] = 8'h01;
    wr_xfer(my_addr(), 1);
    rd_xfer(my_addr(), 1);
    check("R5 repeated START keeps old route", {chan_en, chan_sel}, 3'b101);
    bus_stop();
    check("R4 R5 disable after STOP", {chan_en, chan_sel}, 3'b000);

    // R6/R7: upper write bits ignored, flags follow interrupts, multi-byte read
    wbuf[0] = 8'hFC;
    wr_xfer(my_addr(), 1);
    bus_stop();
    irq_n = 2'b01;
    qwait();
    rd_xfer(my_addr(), 3);
    bus_stop();
    irq_n = 2'b10;
    qwait();
    rd_xfer(my_addr(), 2);
    bus_stop();
    check("R4 routing from 0xFC", {chan_en, chan_sel}, 3'b101);

    // R1: new strap value moves the address
    strap = 3'b010;
    wbuf[0] = 8'h05;
    wr_xfer(7'h75, 1);
    bus_stop();
    check("R1 old address now ignored", {chan_en, chan_sel}, 3'b101);
    wr_xfer(my_addr(), 1);
    bus_stop();
    check("R1 new strap address", {chan_en, chan_sel}, 3'b110);

    // random mix
    for (int it = 0; it < 30; it++) begin
      logic [6:0] addr;
      int n;
      irq_n = 2'($urandom_range(0, 3));
      addr = ($urandom_range(0, 3) == 0) ? my_addr() ^ 7'(1 << $urandom_range(0, 6)) : my_addr();
      n = $urandom_range(1, 3);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      qwait();
      if ($urandom_range(0, 2) == 0) begin
        rd_xfer(addr, n);
      end else begin
        wr_xfer(addr, n);
        check_route("R5 random held before STOP");
        if ($urandom_range(0, 1) == 1) begin
          rd_xfer(my_addr(), 1);
          check_route("R5 random held across repeated START");
        end
      end
      bus_stop();
      check_route("R4 random route after STOP");
    end

    // R8: reset mid-run clears register and route
    wbuf[0] = 8'h05;
    wr_xfer(my_addr(), 1);
    bus_stop();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 reset clears route", {chan_en, chan_sel, sda_pull}, 4'b0000);
    rst_n = 1'b1;
    exp_ctrl = '0; exp_act = '0;
    irq_n = 2'b11;
    repeat (4) @(negedge clk);
    rd_xfer(my_addr(), 1);
    bus_stop();
    check_route("R8 route stays off");

    check("R9 no SDA change while SCL high", r9_viol, 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule